// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps receive statistics for a small group of input ports. Each finished packet is presented once as an end-of-packet event on a valid/ready interface. The event carries the port number, the byte length with CRC included, the FCS and alignment error flags, a receive-error flag, a drop mark, and L2 multicast and broadcast indications. From each event the block updates inbound totals, good and dropped packet and octet counts, an exclusive multicast/broadcast pair, a shared FCS/alignment error count, runt and oversize counts split by FCS status, and a fixed length histogram.

A plain read port picks one counter by port and select code and returns it one cycle later. A global clear-mode input turns every read into a read-and-zero. The minimum and maximum frame lengths are plain inputs. The event interface applies back-pressure only during reset. Outside reset `ev_ready` is high, and an event is taken on every rising edge where `ev_valid` and `ev_ready` are both high. The sender keeps the event fields stable while `ev_valid` is high and not yet accepted.

Top module: `rx_port_stats`

## Requirements
- R1: `ev_ready` is low while `rst` is high and high otherwise. An event takes effect only at a rising edge where `ev_valid` is high; event fields presented with `ev_valid` low change nothing.
- R2: An event with `ev_rx_err`=1 adds 1 to the inbound error counter (select 2) and its length to the inbound octet counter (select 1). It changes no other counter.
- R3: An event without a receive error adds 1 to inbound packets (select 0) and its length to inbound octets (select 1). If `ev_drop`=1 it also adds 1 to dropped packets (select 5) and its length to dropped octets (select 6). Otherwise it adds 1 to good packets (select 3) and its length to good octets (select 4).
- R4: For a packet without a receive error whose length L lies in 64..`max_len`, exactly one histogram bin advances. The bins are 64 (select 14), 65–127 (15), 128–255 (16), 256–511 (17), 512–1023 (18), 1024–1518 (19) and 1519–`max_len` (20). Lengths outside that range advance no bin.
- R5: The multicast counter (select 7) counts packets without a receive error that have `ev_l2`=1, `ev_mcast`=1 and `ev_bcast`=0. The broadcast counter (select 8) counts those with `ev_l2`=1, `ev_bcast`=1 and `ev_mcast`=0.
- R6: A packet without a receive error that has `ev_fcs_err` or `ev_align_err` set adds 1 to a single shared counter (select 9).
- R7: For packets without a receive error: L < `min_len` with no FCS error counts at select 10, and with an FCS error at select 11. L > `max_len` with no FCS error counts at select 12, and with an FCS error at select 13.
- R8: The inbound octet counter is OCT_W bits (default 64), the inbound error counter is ERR_W bits (default 16), and all others are CNT_W bits (default 32). Every counter saturates at its all-ones value and never wraps.
- R9: A read with `rd_en`=1 at a rising edge sets `rd_valid` high after that edge, and only then. `rd_data` holds the selected counter's value from before that edge's increment, zero-extended. A select code of 21 or above returns 0.
- R10: When `rd_clr`=1, the counter that was read is zeroed at the read edge. If an event increments the same counter at that edge, the returned value excludes the increment and the counter restarts at the increment amount.
- R11: After reset all counters read 0, and `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | End-of-packet event present |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_port | input | PORT_W | Port number of the event |
| ev_len | input | LEN_W | Packet length in bytes including CRC |
| ev_fcs_err | input | 1 | FCS error on this packet |
| ev_align_err | input | 1 | Alignment error on this packet |
| ev_rx_err | input | 1 | Receive-interface error on this packet |
| ev_drop | input | 1 | Packet marked for drop |
| ev_l2 | input | 1 | Packet was parsed from L2 |
| ev_mcast | input | 1 | L2 multicast destination |
| ev_bcast | input | 1 | L2 broadcast destination |
| min_len | input | LEN_W | Minimum frame length |
| max_len | input | LEN_W | Maximum frame length |
| rd_clr | input | 1 | Reads zero the counter they return |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_sel | input | 5 | Counter select code |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | DATA_W | Read result |

## Verification
The bench sweeps every length across the histogram, runt and oversize edges under two sets of frame limits, with flag patterns that cover every multicast/broadcast combination. A wrong bin boundary or a non-exclusive cast count would show up as a mismatch in a neighbouring bin. The bench pushes the octet and error counters past their limits with a narrow configuration, so a wrapping counter reads as a small value. It also drives an event into the very counter being read in the same cycle, with clear mode on and off. A design that folded the increment into the returned value, or that lost the increment after clearing, fails there. Reads of invalid select codes and events held with `ev_valid` low catch a mux that aliases or an update that ignores the handshake.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int NCNT  = 21;
  localparam int SEL_W = 5;

  localparam int SEL_INB_PKTS  = 0;
  localparam int SEL_INB_OCTS  = 1;
  localparam int SEL_INB_ERRS  = 2;
  localparam int SEL_PKTS      = 3;
  localparam int SEL_OCTS      = 4;
  localparam int SEL_DROP_PKTS = 5;
  localparam int SEL_DROP_OCTS = 6;
  localparam int SEL_MCAST     = 7;
  localparam int SEL_BCAST     = 8;
  localparam int SEL_FCS_ALN   = 9;
  localparam int SEL_RUNT      = 10;
  localparam int SEL_FRAG      = 11;
  localparam int SEL_OVER      = 12;
  localparam int SEL_JABBER    = 13;
  localparam int SEL_BIN0      = 14;
  localparam int NBINS         = 7;

  // Counters that advance by the packet length rather than by one.
  function automatic bit is_octet(int idx);
    return idx == SEL_INB_OCTS || idx == SEL_OCTS || idx == SEL_DROP_OCTS;
  endfunction

  function automatic int cnt_width(int idx, int cw, int ow, int ew);
    if (idx == SEL_INB_OCTS) return ow;
    if (idx == SEL_INB_ERRS) return ew;
    return cw;
  endfunction

  // Lower edge of each histogram bin in bytes.
  function automatic int bin_lo(int k);
    case (k)
      0: return 64;
      1: return 65;
      2: return 128;
      3: return 256;
      4: return 512;
      5: return 1024;
      default: return 1519;
    endcase
  endfunction
endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic             fcs_err,
  input  logic             align_err,
  input  logic             rx_err,
  input  logic             drop,
  input  logic             l2,
  input  logic             mcast,
  input  logic             bcast,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  output logic [NCNT-1:0]  hit
);
  logic       good;
  logic       is_short;
  logic       is_long;
  logic [NBINS-1:0] bin_hit;

  assign good     = !rx_err;
  assign is_short = len < min_len;
  assign is_long  = len > max_len;

  for (genvar k = 0; k < NBINS; k++) begin : g_bin
    localparam int LO = bin_lo(k);
    localparam int HI = (k == NBINS - 1) ? 0 : bin_lo(k + 1) - 1;
    logic in_lo;
    logic in_hi;
    assign in_lo = int'(len) >= LO;
    if (k == NBINS - 1) begin : g_top
      assign in_hi = 1'b1;
    end else begin : g_mid
      assign in_hi = int'(len) <= HI;
    end
    assign bin_hit[k] = good && in_lo && in_hi && !is_long;
  end

  always_comb begin
    hit                = '0;
    hit[SEL_INB_ERRS]  = rx_err;
    hit[SEL_INB_OCTS]  = 1'b1;
    hit[SEL_INB_PKTS]  = good;
    hit[SEL_PKTS]      = good && !drop;
    hit[SEL_OCTS]      = good && !drop;
    hit[SEL_DROP_PKTS] = good && drop;
    hit[SEL_DROP_OCTS] = good && drop;
    hit[SEL_MCAST]     = good && l2 && mcast && !bcast;
    hit[SEL_BCAST]     = good && l2 && bcast && !mcast;
    hit[SEL_FCS_ALN]   = good && (fcs_err || align_err);
    hit[SEL_RUNT]      = good && is_short && !fcs_err;
    hit[SEL_FRAG]      = good && is_short && fcs_err;
    hit[SEL_OVER]      = good && is_long && !fcs_err;
    hit[SEL_JABBER]    = good && is_long && fcs_err;
    for (int k = 0; k < NBINS; k++) hit[SEL_BIN0 + k] = bin_hit[k];
  end
endmodule

// File: rtl/rxs_sat_counter.sv
module rxs_sat_counter #(
  parameter int W     = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [AMT_W-1:0] amt,
  input  logic             clr,
  output logic [W-1:0]     cnt
);
  localparam int SUM_W = ((W > AMT_W) ? W : AMT_W) + 1;
  localparam logic [SUM_W-1:0] MAXV = {{(SUM_W - W){1'b0}}, {W{1'b1}}};

  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic [W-1:0]     cnt_d;

  always_comb begin
    base  = clr ? '0 : SUM_W'(cnt);
    sum   = base + (inc ? SUM_W'(amt) : '0);
    cnt_d = (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc || clr) cnt <= cnt_d;
  end
endmodule

// File: rtl/rxs_read_port.sv
module rxs_read_port
  import rxs_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PORT_W = 2,
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic                     rd_clr,
  input  logic [PORT_W-1:0]        rd_port,
  input  logic [SEL_W-1:0]         rd_sel,
  input  logic [DATA_W-1:0]        vals [NPORTS*NCNT],
  output logic [NPORTS*NCNT-1:0]   clr_vec,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data
);
  logic              sel_ok;
  int                idx;
  logic [DATA_W-1:0] pick;

  always_comb begin
    sel_ok  = (int'(rd_sel) < NCNT) && (int'(rd_port) < NPORTS);
    idx     = int'(rd_port) * NCNT + int'(rd_sel);
    pick    = '0;
    clr_vec = '0;
    if (sel_ok) begin
      pick = vals[idx];
      if (rd_en && rd_clr) clr_vec[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= pick;
    end
  end
endmodule

// File: rtl/rx_port_stats.sv
module rx_port_stats
  import rxs_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int OCT_W  = 64,
  parameter int ERR_W  = 16,
  parameter int DATA_W = 64,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_fcs_err,
  input  logic              ev_align_err,
  input  logic              ev_rx_err,
  input  logic              ev_drop,
  input  logic              ev_l2,
  input  logic              ev_mcast,
  input  logic              ev_bcast,
  input  logic [LEN_W-1:0]  min_len,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              rd_clr,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NTOT = NPORTS * NCNT;

  logic              accept;
  logic [NCNT-1:0]   hit;
  logic [NTOT-1:0]   clr_vec;
  logic [DATA_W-1:0] vals [NTOT];

  assign ev_ready = !rst;
  assign accept   = ev_valid && ev_ready;

  rxs_classify #(.LEN_W(LEN_W)) u_classify (
    .len       (ev_len),
    .fcs_err   (ev_fcs_err),
    .align_err (ev_align_err),
    .rx_err    (ev_rx_err),
    .drop      (ev_drop),
    .l2        (ev_l2),
    .mcast     (ev_mcast),
    .bcast     (ev_bcast),
    .min_len   (min_len),
    .max_len   (max_len),
    .hit       (hit)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic port_hit;
    assign port_hit = accept && (int'(ev_port) == p);
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      localparam int  W   = cnt_width(c, CNT_W, OCT_W, ERR_W);
      localparam bit  OCT = is_octet(c);
      logic [W-1:0]     q;
      logic [LEN_W-1:0] amt;
      assign amt = OCT ? ev_len : LEN_W'(1);
      rxs_sat_counter #(.W(W), .AMT_W(LEN_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (port_hit && hit[c]),
        .amt (amt),
        .clr (clr_vec[p*NCNT + c]),
        .cnt (q)
      );
      assign vals[p*NCNT + c] = DATA_W'(q);
    end
  end

  rxs_read_port #(.NPORTS(NPORTS), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_clr   (rd_clr),
    .rd_port  (rd_port),
    .rd_sel   (rd_sel),
    .vals     (vals),
    .clr_vec  (clr_vec),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/rx_port_stats_chk.sv
module rx_port_stats_chk
  import rxs_pkg::*;
#(
  parameter int PORT_W = 2,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              rd_en,
  input logic              rd_clr,
  input logic [PORT_W-1:0] rd_port,
  input logic [SEL_W-1:0]  rd_sel,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  AST_RD_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R9
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid); // R9
  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_sel) >= NCNT) |=> rd_data == '0); // R9
  AST_CLEARED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_clr && !ev_valid) ##1
    (rd_en && rd_port == $past(rd_port) && rd_sel == $past(rd_sel))
    |=> rd_data == '0); // R10
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_clr) ##1
    (rd_en && rd_port == $past(rd_port) && rd_sel == $past(rd_sel))
    |=> rd_data >= $past(rd_data)); // R8
endmodule

bind rx_port_stats rx_port_stats_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_valid (ev_valid),
  .rd_en    (rd_en),
  .rd_clr   (rd_clr),
  .rd_port  (rd_port),
  .rd_sel   (rd_sel),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/rx_port_stats_bench.sv
`timescale 1ns/1ps
module rx_port_stats_bench;
  localparam int NP = 4;
  localparam int NC = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [1:0]  ev_port = '0;
  logic [15:0] ev_len = '0;
  logic        ev_fcs_err = 0, ev_align_err = 0, ev_rx_err = 0, ev_drop = 0;
  logic        ev_l2 = 0, ev_mcast = 0, ev_bcast = 0;
  logic [15:0] min_len = 16'd64;
  logic [15:0] max_len = 16'd1518;
  logic        rd_clr = 0, rd_en = 0;
  logic [1:0]  rd_port = '0;
  logic [4:0]  rd_sel = '0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int errors = 0;
  int checks = 0;
  longint unsigned model [NP][NC];

  always #2 clk = ~clk;

  rx_port_stats #(.NPORTS(4), .LEN_W(16), .CNT_W(20), .OCT_W(40), .ERR_W(10), .DATA_W(64))
  u_rx_port_stats (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_port(ev_port),
    .ev_len(ev_len), .ev_fcs_err(ev_fcs_err), .ev_align_err(ev_align_err),
    .ev_rx_err(ev_rx_err), .ev_drop(ev_drop), .ev_l2(ev_l2), .ev_mcast(ev_mcast),
    .ev_bcast(ev_bcast), .min_len(min_len), .max_len(max_len), .rd_clr(rd_clr),
    .rd_en(rd_en), .rd_port(rd_port), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int mw(int c);
    if (c == 1) return 40;
    if (c == 2) return 10;
    return 20;
  endfunction

  function automatic string req_of(int c);
    if (c == 2 || c == 1) return "R2";
    if (c <= 6) return "R3";
    if (c <= 8) return "R5";
    if (c == 9) return "R6";
    if (c <= 13) return "R7";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void madd(int p, int c, longint unsigned amt);
    longint unsigned lim = (64'd1 << mw(c)) - 1;
    longint unsigned v = model[p][c] + amt;
    model[p][c] = (v > lim) ? lim : v;
  endfunction

  // Expected counter effects of one accepted event, from the requirements.
  function automatic void apply(int p, int len, bit fcs, bit aln, bit rxe, bit drp,
                                bit l2, bit mc, bit bc);
    int mn = int'(min_len);
    int mx = int'(max_len);
    if (rxe) begin
      madd(p, 2, 1); madd(p, 1, len);
      return;
    end
    madd(p, 0, 1); madd(p, 1, len);
    if (drp) begin madd(p, 5, 1); madd(p, 6, len); end
    else begin madd(p, 3, 1); madd(p, 4, len); end
    if (l2 && mc && !bc) madd(p, 7, 1);
    if (l2 && bc && !mc) madd(p, 8, 1);
    if (fcs || aln) madd(p, 9, 1);
    if (len < mn) madd(p, fcs ? 11 : 10, 1);
    if (len > mx) madd(p, fcs ? 13 : 12, 1);
    if (len >= 64 && len <= mx) begin
      if (len == 64) madd(p, 14, 1);
      else if (len <= 127) madd(p, 15, 1);
      else if (len <= 255) madd(p, 16, 1);
      else if (len <= 511) madd(p, 17, 1);
      else if (len <= 1023) madd(p, 18, 1);
      else if (len <= 1518) madd(p, 19, 1);
      else madd(p, 20, 1);
    end
  endfunction

  task automatic drive_ev(int p, int len, bit fcs, bit aln, bit rxe, bit drp, bit l2, bit mc, bit bc);
    ev_port = 2'(p); ev_len = 16'(len); ev_fcs_err = fcs; ev_align_err = aln;
    ev_rx_err = rxe; ev_drop = drp; ev_l2 = l2; ev_mcast = mc; ev_bcast = bc;
  endtask

  task automatic send(int p, int len, bit fcs, bit aln, bit rxe, bit drp, bit l2, bit mc, bit bc);
    drive_ev(p, len, fcs, aln, rxe, drp, l2, mc, bc);
    ev_valid = 1'b1;
    apply(p, len, fcs, aln, rxe, drp, l2, mc, bc);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic read_chk(int p, int s, bit clr, string tag);
    longint unsigned exp = (s < NC) ? model[p][s] : 0;
    rd_en = 1'b1; rd_port = 2'(p); rd_sel = 5'(s); rd_clr = clr;
    @(negedge clk);
    rd_en = 1'b0; rd_clr = 1'b0;
    check(rd_valid === 1'b1 && rd_data === exp, tag, rd_data, exp);
    if (clr && s < NC) model[p][s] = 0;
  endtask

  // Event and read of the same counter in one cycle.
  task automatic collide(int p, int s, bit clr, int len, string tag);
    longint unsigned exp = model[p][s];
    drive_ev(p, len, 0, 0, 0, 0, 0, 0, 0);
    ev_valid = 1'b1;
    rd_en = 1'b1; rd_port = 2'(p); rd_sel = 5'(s); rd_clr = clr;
    if (clr) model[p][s] = 0;
    apply(p, len, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    ev_valid = 1'b0; rd_en = 1'b0; rd_clr = 1'b0;
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic read_all(bit clr, string why);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NC; s++)
        read_chk(p, s, clr, clr ? "R10" : req_of(s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (R1) actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int s = 0; s < NC; s++) model[p][s] = 0;
    repeat (3) @(negedge clk);
    check(ev_ready === 1'b0, "R1 ready low in reset", ev_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ev_ready === 1'b1, "R1 ready high", ev_ready, 1);
    check(rd_valid === 1'b0, "R11 rd_valid", rd_valid, 0);
    check(rd_data === 64'd0, "R11 rd_data", rd_data, 0);
    for (int s = 0; s < NC; s++) read_chk(0, s, 0, "R11");

    // Fields present but ev_valid low: nothing may count.
    drive_ev(0, 300, 1, 1, 0, 0, 1, 1, 0);
    repeat (2) @(negedge clk);
    read_chk(0, 1, 0, "R1 idle octets");
    read_chk(0, 0, 0, "R1 idle packets");

    // Sweep 1: default frame limits, every length with rotating flags.
    for (int len = 0; len <= 1600; len++)
      send(len % 4, len, (len % 7) == 0, (len % 11) == 3, (len % 13) == 5,
           (len % 5) == 2, (len % 3) != 0, ((len / 2) % 2) == 1, ((len / 4) % 2) == 1);
    read_all(0, "sweep1");

    // Sweep 2: tighter limits, then read-clear and confirm zeros.
    min_len = 16'd100; max_len = 16'd1000;
    @(negedge clk);
    for (int len = 0; len <= 1200; len++)
      send((len / 3) % 4, len, (len % 6) == 1, (len % 9) == 4, (len % 17) == 8,
           (len % 4) == 3, (len % 5) != 1, ((len / 3) % 2) == 1, ((len / 5) % 2) == 1);
    read_all(1, "clear");
    read_all(0, "after clear");

    // Saturation with the narrow bench widths.
    for (int i = 0; i < 20; i++) send(1, 60000, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 1030; i++) send(2, 10, 0, 0, 1, 0, 0, 0, 0);
    read_chk(1, 6, 0, "R8 dropped octets saturate");
    check(rd_data === 64'hFFFFF, "R8 literal 20-bit limit", rd_data, 64'hFFFFF);
    read_chk(2, 2, 0, "R8 error count saturates");
    check(rd_data === 64'd1023, "R8 literal 10-bit limit", rd_data, 1023);
    read_chk(2, 1, 0, "R2 error octets");
    read_chk(2, 0, 0, "R2 no inbound packet from errors");

    // Same-cycle event and read.
    min_len = 16'd64; max_len = 16'd1518;
    @(negedge clk);
    send(3, 200, 0, 0, 0, 0, 0, 0, 0);
    collide(3, 3, 1, 200, "R10 clear+inc returns old");
    read_chk(3, 3, 0, "R10 restart at increment");
    check(rd_data === 64'd1, "R10 packets equal one", rd_data, 1);
    collide(3, 4, 1, 200, "R10 octets clear+inc");
    read_chk(3, 4, 0, "R10 octets restart");
    check(rd_data === 64'd200, "R10 octets equal length", rd_data, 200);
    collide(3, 0, 0, 77, "R9 read excludes same-edge increment");
    read_chk(3, 0, 0, "R9 increment kept");

    // Select codes beyond the map return zero and clear nothing.
    read_chk(0, 25, 1, "R9 invalid select");
    read_chk(0, 21, 0, "R9 invalid select 21");
    read_chk(0, 3, 0, "R9 neighbour intact");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule